// File: doc/BRIEF.md
# Radix-4 Booth Multiply-Accumulate Unit

This block multiplies two signed 8-bit two's-complement operands and adds the product into a running total, at a rate of one operation per clock. The multiplier operand is recoded in radix 4. This produces one partial-product row for each pair of its bits. The rows go into a chain of 3:2 carry-save compressors. The stored accumulator also enters that chain, as a separate sum vector and carry vector. Carries are never propagated around the feedback loop. A single carry-propagate adder at the output turns the stored pair into a binary total.

Each cycle where `in_valid` is high, one operation is accepted. If `clear` is also high, the total restarts from the new product. Otherwise the product is added to the old total. The resolved total appears on `result` one clock later, and `result_valid` marks that cycle.

A two-state machine drives `result_valid`. The state `ST_IDLE` means no operation was accepted on the previous edge. The state `ST_PRESENT` means one was. There are two transitions. `in_valid` high moves the machine (from either state) to `ST_PRESENT`. `in_valid` low moves it to `ST_IDLE`. Reset forces `ST_IDLE`.

Top module: `booth_mac`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) zeroes both halves of the accumulator. After that edge, `result` reads 0 and `result_valid` reads 0.
- R2: `result_valid` is 1 in the cycle that follows an edge where `in_valid` was 1. It is 0 after an edge where `in_valid` was 0.
- R3: With `in_valid` and `clear` both high, the next `result` is the signed product of `x_in` and `y_in`, sign-extended to 20 bits. Example: 0xE7 times 0x1E gives 0xFFD12. Example: 0x2D times 0xF1 gives 0xFFD5D.
- R4: With `in_valid` high and `clear` low, the next `result` is the previous total plus the signed product.
- R5: `clear` discards the previous total. For example, a clear operation with `x_in` = 0 gives a `result` of 0, whatever the old total was.
- R6: While `in_valid` is low, the total does not change and `clear` has no effect.
- R7: The total is 20 bits wide and wraps modulo 2^20. Overflow is not detected and is not saturated.
- R8: Every radix-4 digit in the set {-2,-1,0,+1,+2} is formed correctly. This includes the operand extremes -128 and 127 on both inputs. For example, -128 times -128 gives 16384.
- R9: An accepted operation without `clear`, where either operand is zero, leaves the total unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clear | input | 1 | Restart the total from this product |
| in_valid | input | 1 | Accept x_in and y_in on this edge |
| x_in | input | 8 | Multiplicand, signed |
| y_in | input | 8 | Multiplier, signed, Booth-recoded |
| result | output | 20 | Resolved accumulator total, signed |
| result_valid | output | 1 | High the cycle after an accepted operation |

## Verification
The bench uses the default widths: 8-bit operands and 4 guard bits, which gives a 20-bit total. With these widths all 65,536 operand pairs fit into one sweep of clear-and-multiply operations. That sweep reaches every Booth digit combination in every row position, and it includes both operand extremes. Further sequences check accumulation over long runs, wrap-around past 2^19, idle cycles with `clear` asserted, and reset in the middle of a run. All expected totals are computed with integer arithmetic in the bench.

// File: rtl/booth_mac_pkg.sv
package booth_mac_pkg;

    // one radix-4 digit: magnitude select and sign
    typedef struct packed {
        logic neg;
        logic one;
        logic two;
    } booth_digit_t;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_PRESENT = 1'b1
    } out_state_e;

    // triplet is {y[2k+1], y[2k], y[2k-1]}
    function automatic booth_digit_t recode(input logic [2:0] trip);
        booth_digit_t d;
        d.neg = trip[2] & ~(trip[1] & trip[0]);
        d.one = trip[1] ^ trip[0];
        d.two = (trip == 3'b011) || (trip == 3'b100);
        return d;
    endfunction

endpackage

// File: rtl/booth_pp_gen.sv
module booth_pp_gen
    import booth_mac_pkg::*;
#(
    parameter int A_W   = 8,
    parameter int OUT_W = 20
) (
    input  logic [A_W-1:0]                      x_op,
    input  logic [A_W-1:0]                      y_op,
    output logic [A_W/2-1:0][OUT_W-1:0]         rows,
    output logic [OUT_W-1:0]                    neg_row
);
    localparam int ROWS = A_W / 2;

    logic [OUT_W-1:0] x_ext;
    logic [A_W:0]     y_pad;
    logic [ROWS-1:0]  neg_bits;

    assign x_ext = {{(OUT_W-A_W){x_op[A_W-1]}}, x_op};
    assign y_pad = {y_op, 1'b0};

    for (genvar k = 0; k < ROWS; k++) begin : g_row
        booth_digit_t     dig;
        logic [OUT_W-1:0] mag;
        always_comb begin
            dig = recode(y_pad[2*k +: 3]);
            unique case ({dig.two, dig.one})
                2'b01:   mag = x_ext;
                2'b10:   mag = x_ext << 1;
                default: mag = '0;
            endcase
            rows[k]     = (mag ^ {OUT_W{dig.neg}}) << (2*k);
            neg_bits[k] = dig.neg;
        end
    end

    // the +1 of each negated row is gathered into one extra row
    always_comb begin
        neg_row = '0;
        for (int k = 0; k < ROWS; k++) begin
            neg_row[2*k] = neg_bits[k];
        end
    end

endmodule

// File: rtl/csa_chain.sv
module csa_chain #(
    parameter int W    = 20,
    parameter int NOPS = 7
) (
    input  logic [NOPS-1:0][W-1:0] ops,
    output logic [W-1:0]           sum_o,
    output logic [W-1:0]           carry_o
);
    localparam int STAGES = NOPS - 2;

    logic [STAGES:0][W-1:0] s_q;
    logic [STAGES:0][W-1:0] c_q;

    assign s_q[0] = ops[0];
    assign c_q[0] = ops[1];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic [W-1:0] a, b, c;
        assign a = s_q[i];
        assign b = c_q[i];
        assign c = ops[i+2];
        assign s_q[i+1] = a ^ b ^ c;
        assign c_q[i+1] = ((a & b) | (a & c) | (b & c)) << 1;
    end

    assign sum_o   = s_q[STAGES];
    assign carry_o = c_q[STAGES];

endmodule

// File: rtl/cp_adder.sv
module cp_adder #(
    parameter int W = 20
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] s
);
    assign s = a + b;
endmodule

// File: rtl/booth_mac.sv
module booth_mac
    import booth_mac_pkg::*;
#(
    parameter int A_W   = 8,
    parameter int GUARD = 4,
    parameter int ACC_W = 2*A_W + GUARD
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             in_valid,
    input  logic [A_W-1:0]   x_in,
    input  logic [A_W-1:0]   y_in,
    output logic [ACC_W-1:0] result,
    output logic             result_valid
);
    localparam int ROWS = A_W / 2;
    localparam int NOPS = ROWS + 3;

    logic [ROWS-1:0][ACC_W-1:0] pp_rows;
    logic [ACC_W-1:0]           pp_neg;
    logic [ACC_W-1:0]           acc_sum_q, acc_carry_q;
    logic [ACC_W-1:0]           fb_sum, fb_carry;
    logic [ACC_W-1:0]           nxt_sum, nxt_carry;
    logic [NOPS-1:0][ACC_W-1:0] tree_in;
    out_state_e                 state_q, state_d;

    booth_pp_gen #(.A_W(A_W), .OUT_W(ACC_W)) pp_i (
        .x_op    (x_in),
        .y_op    (y_in),
        .rows    (pp_rows),
        .neg_row (pp_neg)
    );

    // clear drops the stored pair from the reduction
    assign fb_sum   = clear ? '0 : acc_sum_q;
    assign fb_carry = clear ? '0 : acc_carry_q;

    always_comb begin
        tree_in[0] = fb_sum;
        tree_in[1] = fb_carry;
        tree_in[2] = pp_neg;
        for (int k = 0; k < ROWS; k++) begin
            tree_in[3+k] = pp_rows[k];
        end
    end

    csa_chain #(.W(ACC_W), .NOPS(NOPS)) csa_i (
        .ops     (tree_in),
        .sum_o   (nxt_sum),
        .carry_o (nxt_carry)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_sum_q   <= '0;
            acc_carry_q <= '0;
        end else if (in_valid) begin
            acc_sum_q   <= nxt_sum;
            acc_carry_q <= nxt_carry;
        end
    end

    // state register
    always_comb begin
        state_d = in_valid ? ST_PRESENT : ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_PRESENT: result_valid = 1'b1;
            ST_IDLE:    result_valid = 1'b0;
            default:    result_valid = 1'b0;
        endcase
    end

    cp_adder #(.W(ACC_W)) cpa_i (
        .a (acc_sum_q),
        .b (acc_carry_q),
        .s (result)
    );

endmodule

// File: rtl/booth_mac_sva.sv
module booth_mac_sva #(
    parameter int A_W   = 8,
    parameter int ACC_W = 20
) (
    input logic             clk,
    input logic             rst,
    input logic             clear,
    input logic             in_valid,
    input logic [A_W-1:0]   x_in,
    input logic [A_W-1:0]   y_in,
    input logic [ACC_W-1:0] result,
    input logic             result_valid
);
    a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (result == '0 && !result_valid));

    a_r2_valid_next: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> result_valid);

    a_r2_quiet_next: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !result_valid);

    a_r5_clear_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && clear && x_in == '0) |=> (result == '0));

    a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    a_r9_zero_operand: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !clear && (x_in == '0 || y_in == '0)) |=> $stable(result));
endmodule

bind booth_mac booth_mac_sva #(.A_W(A_W), .ACC_W(ACC_W)) sva_i (
    .clk          (clk),
    .rst          (rst),
    .clear        (clear),
    .in_valid     (in_valid),
    .x_in         (x_in),
    .y_in         (y_in),
    .result       (result),
    .result_valid (result_valid)
);

// File: tb/booth_mac_tb.sv
module booth_mac_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int A_W   = 8;
    localparam int ACC_W = 20;

    logic             clk = 1'b0;
    logic             rst;
    logic             clear;
    logic             in_valid;
    logic [A_W-1:0]   x_in;
    logic [A_W-1:0]   y_in;
    logic [ACC_W-1:0] result;
    logic             result_valid;

    int checks   = 0;
    int failures = 0;
    logic [ACC_W-1:0] exp_acc = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    booth_mac dut_i (
        .clk          (clk),
        .rst          (rst),
        .clear        (clear),
        .in_valid     (in_valid),
        .x_in         (x_in),
        .y_in         (y_in),
        .result       (result),
        .result_valid (result_valid)
    );

    task automatic check_val(input string req, input logic [ACC_W-1:0] act,
                             input logic [ACC_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%05h expected=0x%05h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge after checking
    task automatic op(input logic v, input logic c, input logic [7:0] a,
                      input logic [7:0] b, input string req);
        int p;
        in_valid = v; clear = c; x_in = a; y_in = b;
        p = int'($signed(a)) * int'($signed(b));
        if (v) exp_acc = c ? ACC_W'(p) : exp_acc + ACC_W'(p);
        @(negedge clk);
        check_val("R2", ACC_W'(result_valid), ACC_W'(v));
        check_val(req, result, exp_acc);
    endtask

    task automatic do_reset();
        rst = 1'b1; in_valid = 1'b0; clear = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        exp_acc = '0;
        check_val("R1", result, '0);
        check_val("R1", ACC_W'(result_valid), '0);
    endtask

    initial begin
        rst = 1'b1; clear = 1'b0; in_valid = 1'b0; x_in = '0; y_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_val("R1", result, '0);
        check_val("R1", ACC_W'(result_valid), '0);

        // R3 and R8: exhaustive clear-and-multiply sweep
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                op(1'b1, 1'b1, 8'(a), 8'(b), "R3/R8");
            end
        end
        // R3 worked examples
        op(1'b1, 1'b1, 8'hE7, 8'h1E, "R3");
        check_val("R3", result, 20'hFFD12);
        op(1'b1, 1'b1, 8'h2D, 8'hF1, "R3");
        check_val("R3", result, 20'hFFD5D);
        // R8 extreme
        op(1'b1, 1'b1, 8'h80, 8'h80, "R8");
        check_val("R8", result, 20'd16384);

        // R4: accumulation run
        for (int i = 0; i < 256; i++) begin
            op(1'b1, 1'b0, 8'(i), 8'(255 - 3*i), "R4");
        end

        // R6: idle cycles with clear asserted
        op(1'b1, 1'b1, 8'd100, 8'd37, "R5");
        for (int i = 0; i < 5; i++) op(1'b0, 1'b1, 8'(i), 8'd9, "R6");
        // R9: zero operand
        op(1'b1, 1'b0, 8'd0, 8'd77, "R9");
        op(1'b1, 1'b0, 8'hC3, 8'd0, "R9");
        // R5: clear with zero product
        op(1'b1, 1'b1, 8'd0, 8'h55, "R5");
        check_val("R5", result, '0);

        // R7: wrap past 2^19 and round to zero
        op(1'b1, 1'b1, 8'h80, 8'h80, "R7");
        for (int i = 0; i < 70; i++) op(1'b1, 1'b0, 8'h80, 8'h80, "R7");
        check_val("R7", result, ACC_W'(71 * 16384));
        for (int i = 0; i < 70; i++) op(1'b1, 1'b0, 8'h80, 8'h7F, "R7");

        // R1: reset mid-run
        op(1'b1, 1'b0, 8'h7F, 8'h7F, "R4");
        do_reset();
        op(1'b1, 1'b0, 8'h05, 8'hFD, "R4");
        check_val("R4", result, ACC_W'(-15));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule